// File: doc/BRIEF.md
# Pixel Clock-Crossing Line FIFO

This block moves a stream of 24-bit RGB pixels from a fast, fixed pipeline clock (nominally 100 MHz) into the display pixel clock, which runs at 30 MHz for the 50 Hz mode or 40 MHz for the 60 Hz mode. Upstream logic produces a real pixel only on some pipeline cycles, and it marks those cycles with a valid strobe. The block acknowledges each pixel that it stores with a one-cycle commit strobe. On the display side, a line-active request pulls one pixel per pixel-clock cycle, and the block marks each delivered pixel with a data-valid flag. The clock multiplexer that selects 30 or 40 MHz sits outside the block and appears here as a single read-clock input.

Storage is an asynchronous FIFO. Its read and write pointers are Gray coded, and each pointer reaches the other clock domain through a two-flop synchronizer. When a line starts, the read side waits until the buffer holds more than an almost-empty threshold. This prefill absorbs the irregular arrival of input pixels. The FIFO may drain completely at the end of every raster line and then starts afresh on the next line. After the shared reset input is released, the write side runs a short reset sequence, and it accepts no pixels until that sequence has finished.

Top module: `pixel_cdc_fifo`

## Requirements
- R1: While `rst` is high and afterwards until the first pixel is accepted, `wrCommit`, `wrOverflow`, `rdUnderflow` and `rdValid` are 0 and `rdPixel` is 0. A new reset also clears sticky flags that were set before it.
- R2: No write is accepted during reset or during the first 4 write-clock cycles after `rst` is released. Such writes produce no `wrCommit`. With `wrValid` held high, writes begin to commit within 10 write-clock cycles of the release.
- R3: Each accepted pixel produces exactly one `wrCommit` pulse, one write-clock cycle long. The pulse is high in the write-clock cycle that follows the rising edge that sampled `wrValid` high.
- R4: Pixels leave in the order they were written, with their values unchanged. `rdValid` is high for exactly one read-clock cycle per pixel, and a pixel is delivered only while `rdLineActive` is high.
- R5: After `rdLineActive` rises, no pixel is read until more than 8 pixels are held. With 8 or fewer stored, `rdValid` stays 0 and no underflow is recorded.
- R6: Dropping `rdLineActive` ends reads at once. The following line, at either read-clock rate, gates on the prefill again and then delivers its complete pixel count with no underflow.
- R7: The capacity is 64 pixels. A write presented while the FIFO is full is dropped, gives no `wrCommit`, and sets `wrOverflow`, which stays set until reset.
- R8: A read attempted while the line is running and the FIFO is empty drives `rdPixel` to 0 (black) with `rdValid` low, and sets `rdUnderflow`, which stays set until reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| wrClk | input | 1 | Pipeline (write) clock |
| rdClk | input | 1 | Display pixel (read) clock, 30 or 40 MHz |
| rst | input | 1 | Active-high reset: asserts asynchronously, released synchronously in each domain |
| wrValid | input | 1 | A real pixel is present on `wrPixel` in this cycle |
| wrPixel | input | 24 | RGB pixel to store |
| wrCommit | output | 1 | One-cycle pulse for each pixel placed into storage |
| wrOverflow | output | 1 | Sticky: a write was dropped because the FIFO was full |
| rdLineActive | input | 1 | The display requests one pixel per read-clock cycle |
| rdPixel | output | 24 | Delivered pixel; 0 when no pixel is delivered |
| rdValid | output | 1 | `rdPixel` holds a pixel taken from the FIFO |
| rdUnderflow | output | 1 | Sticky: a read was attempted while the FIFO was empty |

## Verification
`wrCommit` is due one write-clock cycle after the edge that accepted the pixel. The bench samples it on the next falling edge of `wrClk` after every cycle in which it drives `wrValid`, and it counts the pulses per burst. A delivered pixel shows up on `rdPixel` and `rdValid` one read-clock edge after the pop decision, and it is sampled on the falling edge of `rdClk`. Crossing the clock domains adds a few cycles of uncertain latency, so every check that involves both clocks uses a bounded window: a maximum number of read cycles to collect a line, a fixed wait to show that a read is being held off, and a 4-cycle window with no commits after reset. Order, values and counts are checked exactly inside those windows.

// File: rtl/pxf_pkg.sv
`timescale 1ns/1ps
package pxf_pkg;

  // Strobes from the control section to the storage datapath
  typedef struct packed {
    logic wrEn;   // store wrPixel at wrAddr this write cycle
    logic rdEn;   // fetch rdAddr into the output register this read cycle
  } pxfStrobe_t;

endpackage

// File: rtl/pxf_sync.sv
`timescale 1ns/1ps
module pxf_sync #(
  parameter int W      = 1,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [W-1:0] stg [STAGES];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) stg[0] <= '0;
    else       stg[0] <= d;
  end

  for (genvar gi = 1; gi < STAGES; gi++) begin : g_stage
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) stg[gi] <= '0;
      else       stg[gi] <= stg[gi-1];
    end
  end

  assign q = stg[STAGES-1];

endmodule

// File: rtl/pxf_ctrl.sv
`timescale 1ns/1ps
module pxf_ctrl
  import pxf_pkg::*;
#(
  parameter int ADDR_W   = 6,
  parameter int AE_LEVEL = 8,
  parameter int RST_SEQ  = 4,
  parameter int SYNC_LEN = 2
) (
  input  logic              wrClk,
  input  logic              rdClk,
  input  logic              rst,
  input  logic              wrValid,
  input  logic              rdLineActive,
  output pxfStrobe_t        strobes,
  output logic [ADDR_W-1:0] wrAddr,
  output logic [ADDR_W-1:0] rdAddr,
  output logic              rdRstN,
  output logic              wrCommit,
  output logic              wrOverflow,
  output logic              rdUnderflow,
  output logic              wrFull,
  output logic              wrReady,
  output logic [ADDR_W:0]   wrGray,
  output logic              rdEmpty
);

  localparam int PW    = ADDR_W + 1;
  localparam int SEQ_W = $clog2(RST_SEQ + 1);

  function automatic logic [PW-1:0] toGray(input logic [PW-1:0] b);
    return b ^ (b >> 1);
  endfunction

  function automatic logic [PW-1:0] fromGray(input logic [PW-1:0] g);
    logic [PW-1:0] b;
    b[PW-1] = g[PW-1];
    for (int i = PW - 2; i >= 0; i--) b[i] = b[i+1] ^ g[i];
    return b;
  endfunction

  // ---------------- reset release per domain ----------------
  logic rstInN, wrRstN;
  assign rstInN = ~rst;

  pxf_sync #(.W(1), .STAGES(SYNC_LEN)) u_wrRst (
    .clk(wrClk), .rstN(rstInN), .d(1'b1), .q(wrRstN));
  pxf_sync #(.W(1), .STAGES(SYNC_LEN)) u_rdRst (
    .clk(rdClk), .rstN(rstInN), .d(1'b1), .q(rdRstN));

  // ---------------- write-side reset sequence ----------------
  logic [SEQ_W-1:0] seqCnt;

  always_ff @(posedge wrClk or negedge wrRstN) begin
    if (!wrRstN) begin
      seqCnt  <= '0;
      wrReady <= 1'b0;
    end else if (!wrReady) begin
      if (seqCnt == SEQ_W'(RST_SEQ - 1)) wrReady <= 1'b1;
      seqCnt <= seqCnt + 1'b1;
    end
  end

  // ---------------- write pointer domain ----------------
  logic [PW-1:0] wrBin, rdGraySync, wrBinNext;
  logic          wrAccept;

  pxf_sync #(.W(PW), .STAGES(SYNC_LEN)) u_rd2wr (
    .clk(wrClk), .rstN(wrRstN), .d(rdGrayQ), .q(rdGraySync));

  assign wrFull    = (wrGray == {~rdGraySync[PW-1:PW-2], rdGraySync[PW-3:0]});
  assign wrAccept  = wrValid & wrReady & ~wrFull;
  assign wrBinNext = wrBin + 1'b1;

  always_ff @(posedge wrClk or negedge wrRstN) begin
    if (!wrRstN) begin
      wrBin      <= '0;
      wrGray     <= '0;
      wrCommit   <= 1'b0;
      wrOverflow <= 1'b0;
    end else begin
      wrCommit <= wrAccept;
      if (wrAccept) begin
        wrBin  <= wrBinNext;
        wrGray <= toGray(wrBinNext);
      end
      if (wrValid && wrReady && wrFull) wrOverflow <= 1'b1;
    end
  end

  // ---------------- read pointer domain ----------------
  logic [PW-1:0] rdBin, rdGrayQ, wrGraySync, rdLevel, rdBinNext;
  logic          almostEmpty, lineGo, rdTry;

  pxf_sync #(.W(PW), .STAGES(SYNC_LEN)) u_wr2rd (
    .clk(rdClk), .rstN(rdRstN), .d(wrGray), .q(wrGraySync));

  assign rdEmpty     = (rdGrayQ == wrGraySync);
  assign rdLevel     = fromGray(wrGraySync) - rdBin;
  assign almostEmpty = (rdLevel <= PW'(AE_LEVEL));
  assign rdTry       = rdLineActive & lineGo;
  assign rdBinNext   = rdBin + 1'b1;

  always_ff @(posedge rdClk or negedge rdRstN) begin
    if (!rdRstN) begin
      rdBin       <= '0;
      rdGrayQ     <= '0;
      lineGo      <= 1'b0;
      rdUnderflow <= 1'b0;
    end else begin
      lineGo <= rdLineActive & (lineGo | ~almostEmpty);
      if (rdTry && !rdEmpty) begin
        rdBin   <= rdBinNext;
        rdGrayQ <= toGray(rdBinNext);
      end
      if (rdTry && rdEmpty) rdUnderflow <= 1'b1;
    end
  end

  assign strobes.wrEn = wrAccept;
  assign strobes.rdEn = rdTry & ~rdEmpty;
  assign wrAddr       = wrBin[ADDR_W-1:0];
  assign rdAddr       = rdBin[ADDR_W-1:0];

endmodule

// File: rtl/pxf_datapath.sv
`timescale 1ns/1ps
module pxf_datapath
  import pxf_pkg::*;
#(
  parameter int PIX_W  = 24,
  parameter int ADDR_W = 6
) (
  input  logic              wrClk,
  input  logic              rdClk,
  input  logic              rdRstN,
  input  pxfStrobe_t        strobes,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [ADDR_W-1:0] rdAddr,
  input  logic [PIX_W-1:0]  wrPixel,
  output logic [PIX_W-1:0]  rdPixel,
  output logic              rdValid
);

  localparam int DEPTH = 1 << ADDR_W;

  logic [PIX_W-1:0] store [DEPTH];

  always_ff @(posedge wrClk) begin
    if (strobes.wrEn) store[wrAddr] <= wrPixel;
  end

  // Output register: a popped pixel, or black when nothing is delivered
  always_ff @(posedge rdClk or negedge rdRstN) begin
    if (!rdRstN) begin
      rdPixel <= '0;
      rdValid <= 1'b0;
    end else if (strobes.rdEn) begin
      rdPixel <= store[rdAddr];
      rdValid <= 1'b1;
    end else begin
      rdPixel <= '0;
      rdValid <= 1'b0;
    end
  end

endmodule

// File: rtl/pixel_cdc_fifo.sv
`timescale 1ns/1ps
module pixel_cdc_fifo
  import pxf_pkg::*;
#(
  parameter int PIX_W    = 24,
  parameter int ADDR_W   = 6,
  parameter int AE_LEVEL = 8,
  parameter int RST_SEQ  = 4
) (
  input  logic             wrClk,
  input  logic             rdClk,
  input  logic             rst,
  input  logic             wrValid,
  input  logic [PIX_W-1:0] wrPixel,
  output logic             wrCommit,
  output logic             wrOverflow,
  input  logic             rdLineActive,
  output logic [PIX_W-1:0] rdPixel,
  output logic             rdValid,
  output logic             rdUnderflow
);

  pxfStrobe_t        strobes;
  logic [ADDR_W-1:0] wrAddr, rdAddr;
  logic              rdRstN, wrFull, wrReady, rdEmpty;
  logic [ADDR_W:0]   wrGray;

  pxf_ctrl #(
    .ADDR_W(ADDR_W), .AE_LEVEL(AE_LEVEL), .RST_SEQ(RST_SEQ), .SYNC_LEN(2)
  ) ctrl_i (
    .wrClk(wrClk), .rdClk(rdClk), .rst(rst), .wrValid(wrValid),
    .rdLineActive(rdLineActive), .strobes(strobes), .wrAddr(wrAddr),
    .rdAddr(rdAddr), .rdRstN(rdRstN), .wrCommit(wrCommit),
    .wrOverflow(wrOverflow), .rdUnderflow(rdUnderflow), .wrFull(wrFull),
    .wrReady(wrReady), .wrGray(wrGray), .rdEmpty(rdEmpty)
  );

  pxf_datapath #(.PIX_W(PIX_W), .ADDR_W(ADDR_W)) data_i (
    .wrClk(wrClk), .rdClk(rdClk), .rdRstN(rdRstN), .strobes(strobes),
    .wrAddr(wrAddr), .rdAddr(rdAddr), .wrPixel(wrPixel),
    .rdPixel(rdPixel), .rdValid(rdValid)
  );

endmodule

// File: rtl/pixel_cdc_fifo_chk.sv
`timescale 1ns/1ps
module pixel_cdc_fifo_chk #(
  parameter int PIX_W = 24,
  parameter int PW    = 7
) (
  input logic             wrClk,
  input logic             rdClk,
  input logic             rst,
  input logic             wrValid,
  input logic             wrCommit,
  input logic             wrOverflow,
  input logic             wrFull,
  input logic             wrReady,
  input logic [PW-1:0]    wrGray,
  input logic             rdLineActive,
  input logic             rdValid,
  input logic [PIX_W-1:0] rdPixel,
  input logic             rdUnderflow,
  input logic             rdEmpty
);

  // R3
  commit_follows_valid_chk: assert property (@(posedge wrClk) disable iff (rst)
    wrCommit |-> $past(wrValid));

  // R2
  seq_blocks_commit_chk: assert property (@(posedge wrClk) disable iff (rst)
    !wrReady |=> !wrCommit);

  // R7
  full_blocks_commit_chk: assert property (@(posedge wrClk) disable iff (rst)
    (wrValid && wrFull) |=> !wrCommit);

  // R7
  overflow_sticky_chk: assert property (@(posedge wrClk) disable iff (rst)
    wrOverflow |=> wrOverflow);

  // R4
  gray_step_chk: assert property (@(posedge wrClk) disable iff (rst)
    $countones(wrGray ^ $past(wrGray)) <= 1);

  // R4
  valid_in_line_chk: assert property (@(posedge rdClk) disable iff (rst)
    rdValid |-> ($past(rdLineActive) && !$past(rdEmpty)));

  // R8
  underflow_sticky_chk: assert property (@(posedge rdClk) disable iff (rst)
    rdUnderflow |=> rdUnderflow);

  // R8
  underflow_black_chk: assert property (@(posedge rdClk) disable iff (rst)
    $rose(rdUnderflow) |-> (rdPixel == '0 && !rdValid));

endmodule

bind pixel_cdc_fifo pixel_cdc_fifo_chk #(.PIX_W(PIX_W), .PW(ADDR_W + 1)) chk_i (
  .wrClk(wrClk), .rdClk(rdClk), .rst(rst), .wrValid(wrValid),
  .wrCommit(wrCommit), .wrOverflow(wrOverflow), .wrFull(wrFull),
  .wrReady(wrReady), .wrGray(wrGray), .rdLineActive(rdLineActive),
  .rdValid(rdValid), .rdPixel(rdPixel), .rdUnderflow(rdUnderflow),
  .rdEmpty(rdEmpty)
);

// File: tb/pixel_cdc_fifo_tb_top.sv
`timescale 1ns/1ps
module pixel_cdc_fifo_tb_top;

  logic        wrClk, rdClk, rst, wrValid, rdLineActive;
  logic [23:0] wrPixel;
  logic        wrCommit, wrOverflow, rdValid, rdUnderflow;
  logic [23:0] rdPixel;

  int errors = 0;
  int checks = 0;
  bit finished = 0;
  int rdHalf = 33;
  int rxGot = 0;
  logic [23:0] rxBuf [256];

  pixel_cdc_fifo dut_i (
    .wrClk(wrClk), .rdClk(rdClk), .rst(rst), .wrValid(wrValid),
    .wrPixel(wrPixel), .wrCommit(wrCommit), .wrOverflow(wrOverflow),
    .rdLineActive(rdLineActive), .rdPixel(rdPixel), .rdValid(rdValid),
    .rdUnderflow(rdUnderflow)
  );

  // 50 MHz write clock; read clock half-period selects the display mode ratio
  initial wrClk = 0;
  always #10 wrClk = ~wrClk;
  initial rdClk = 0;
  always #(rdHalf) rdClk = ~rdClk;

  typedef struct packed {
    logic [15:0] n;
    logic [7:0]  gap;
    logic [15:0] half;
    logic [23:0] base;
  } vec_t;

  // line length, write spacing, read half-period (33: 50 Hz mode, 25: 60 Hz mode), first pixel
  localparam vec_t VECS [4] = '{
    '{16'd40, 8'd1, 16'd33, 24'h100000},
    '{16'd40, 8'd2, 16'd33, 24'h2A0F00},
    '{16'd50, 8'd1, 16'd25, 24'h00FF10},
    '{16'd30, 8'd2, 16'd25, 24'hFFFFE8}
  };

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic doReset();
    rst = 1;
    wrValid = 0;
    rdLineActive = 0;
    repeat (20) @(negedge wrClk);
    rst = 0;
    repeat (12) @(negedge wrClk);
  endtask

  task automatic pushPixels(input int n, input int gap, input logic [23:0] base,
                            output int commits);
    commits = 0;
    for (int i = 0; i < n; i++) begin
      for (int g = 0; g < gap; g++) begin
        @(negedge wrClk);
        if (wrCommit) commits++;
        wrValid = (g == 0);
        wrPixel = base + 24'(i);
      end
    end
    @(negedge wrClk);
    if (wrCommit) commits++;
    wrValid = 0;
    @(negedge wrClk);
    if (wrCommit) commits++;
  endtask

  task automatic readLine(input int n, input int maxCycles);
    int cyc;
    cyc = 0;
    @(negedge rdClk);
    rdLineActive = 1;
    while (rxGot < n && cyc < maxCycles) begin
      @(negedge rdClk);
      cyc++;
      if (rdValid) begin
        if (rxGot < 256) rxBuf[rxGot] = rdPixel;
        rxGot++;
      end
    end
    rdLineActive = 0;
  endtask

  function automatic int countMismatch(input int n, input logic [23:0] base);
    int bad;
    bad = 0;
    for (int i = 0; i < n && i < 256; i++)
      if (rxBuf[i] !== base + 24'(i)) bad++;
    return bad;
  endfunction

  initial begin
    repeat (150000) @(posedge wrClk);
    if (!finished) begin
      finished = 1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    int commits, early, late, bad;
    rst = 1;
    wrValid = 0;
    wrPixel = '0;
    rdLineActive = 0;

    // R1: reset state
    doReset();
    check(wrCommit == 0, "R1", "wrCommit after reset", wrCommit, 0);
    check(wrOverflow == 0 && rdUnderflow == 0, "R1", "sticky flags after reset",
          wrOverflow + rdUnderflow, 0);
    check(rdValid == 0 && rdPixel == 0, "R1", "read output after reset", rdPixel, 0);

    // Vector table: full lines at both read rates, several write spacings
    for (int v = 0; v < 4; v++) begin
      rdHalf = int'(VECS[v].half);
      repeat (4) @(negedge wrClk);
      rxGot = 0;
      fork
        readLine(int'(VECS[v].n), 600);
        pushPixels(int'(VECS[v].n), int'(VECS[v].gap), VECS[v].base, commits);
      join
      check(commits == int'(VECS[v].n), "R3", "commit pulses per line", commits,
            int'(VECS[v].n));
      check(rxGot == int'(VECS[v].n), "R6", "pixels delivered on line", rxGot,
            int'(VECS[v].n));
      bad = countMismatch(int'(VECS[v].n), VECS[v].base);
      check(bad == 0, "R4", "pixel order and value mismatches", bad, 0);
      check(rdUnderflow == 0, "R6", "no underflow over line", rdUnderflow, 0);
      repeat (10) @(negedge rdClk);
    end

    // R2: reset sequence drops early writes
    rst = 1;
    wrPixel = 24'h00ABCD;
    wrValid = 1;
    early = 0;
    repeat (20) begin
      @(negedge wrClk);
      if (wrCommit) early++;
    end
    check(early == 0, "R2", "commits while in reset", early, 0);
    rst = 0;
    early = 0;
    repeat (4) begin
      @(negedge wrClk);
      if (wrCommit) early++;
    end
    check(early == 0, "R2", "commits in first 4 cycles after release", early, 0);
    late = 0;
    repeat (10) begin
      @(negedge wrClk);
      if (wrCommit) late++;
    end
    check(late > 0, "R2", "commits after sequence done", late, 1);
    wrValid = 0;
    doReset();

    // R5: prefill gate holds reads at 8 entries
    rxGot = 0;
    fork
      readLine(9, 400);
      begin
        pushPixels(8, 1, 24'h330000, commits);
        repeat (40) @(negedge rdClk);
        check(rxGot == 0, "R5", "pixels read with 8 held", rxGot, 0);
        check(rdUnderflow == 0, "R5", "no underflow while gated", rdUnderflow, 0);
        pushPixels(1, 1, 24'h330008, commits);
      end
    join
    check(rxGot == 9, "R5", "pixels after ninth write", rxGot, 9);
    bad = countMismatch(9, 24'h330000);
    check(bad == 0, "R5", "prefilled pixel mismatches", bad, 0);
    repeat (10) @(negedge rdClk);

    // R7: overflow at 64 entries
    pushPixels(65, 1, 24'h440000, commits);
    check(commits == 64, "R7", "commits when writing 65", commits, 64);
    check(wrOverflow == 1, "R7", "overflow flag set", wrOverflow, 1);
    rxGot = 0;
    readLine(64, 400);
    check(rxGot == 64, "R7", "pixels held at capacity", rxGot, 64);
    bad = countMismatch(64, 24'h440000);
    check(bad == 0, "R7", "stored pixel mismatches after overflow", bad, 0);
    check(wrOverflow == 1, "R7", "overflow flag sticky", wrOverflow, 1);
    repeat (10) @(negedge rdClk);

    // R8: read past the end while the line is still active
    rxGot = 0;
    fork
      readLine(1000, 80);
      pushPixels(9, 1, 24'h550000, commits);
    join
    check(rxGot == 9, "R8", "pixels before underflow", rxGot, 9);
    check(rdUnderflow == 1, "R8", "underflow flag set", rdUnderflow, 1);
    check(rdValid == 0 && rdPixel == 0, "R8", "black output on empty read",
          rdPixel, 0);
    repeat (4) @(negedge rdClk);
    check(rdUnderflow == 1, "R8", "underflow flag sticky", rdUnderflow, 1);

    // R1: a new reset clears sticky flags
    doReset();
    check(wrOverflow == 0, "R1", "overflow cleared by reset", wrOverflow, 0);
    check(rdUnderflow == 0, "R1", "underflow cleared by reset", rdUnderflow, 0);

    if (!finished) begin
      finished = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule